// File: doc/BRIEF.md
# Ten-Tap Pipelined FIR Filter with Frame Clearing

This block is a direct-form finite impulse response filter with ten fixed signed weights. It takes one signed 32-bit sample per clock and returns one signed 32-bit result per accepted sample, a fixed number of cycles later. The ten history words sit in separate registers, so all ten products are formed in the same cycle. A registered binary adder tree then sums them. All arithmetic wraps modulo 2^32 and is never saturated.

Samples are grouped into frames of `FRAME_LEN` (default 128). A small controller with two states, `ST_IDLE` (no frame open since reset) and `ST_RUN` (frame in progress), decides which accepted sample opens a new frame. It moves from `ST_IDLE` to `ST_RUN` on the first valid sample. In `ST_RUN` it opens a new frame when the caller raises `in_sof`, or when a frame has already taken `FRAME_LEN` samples; otherwise it advances its sample index. The history is emptied in front of the sample that opens a frame, and that sample's result carries `out_sof`.

Top module: `fir_pipe10`

## Requirements
- R1: A synchronous active-high `rst` clears the history, the pipeline and `out_valid`. Pipeline contents from before the reset never appear at the outputs. The first sample after reset sees an all-zero history.
- R2: The weights, applied to the newest sample first, are 13, -2, 9, 11, 26, 18, 95, -43, 6, 74. A frame-opening sample of value 1 followed by zeros gives exactly these outputs in this order, then zeros.
- R3: Each output equals the sum of weight[i] times the sample accepted i samples earlier, for i from 0 to 9, counting only samples of the current frame. The sum is computed modulo 2^32 in two's complement, with no saturation.
- R4: A cycle with `in_valid` low neither shifts the history nor produces an output.
- R5: A new sample can be accepted on every clock cycle. Each accepted sample gives exactly one output, and outputs come out in input order.
- R6: An output appears on the ports exactly `LATENCY` = 5 rising edges after the edge that sampled its input, whatever the traffic pattern.
- R7: `in_valid` high together with `in_sof` high empties all history before the flagged sample enters it.
- R8: In `ST_RUN`, once a frame has taken `FRAME_LEN` samples, the next valid sample opens a new frame and empties the history, with no `in_sof` needed.
- R9: `out_sof` is high, together with `out_valid`, on the output of every frame-opening sample: one flagged by `in_sof`, one opened by R8, or the first sample after reset. It is low on every other cycle.
- R10: `out_valid` equals `in_valid` delayed by `LATENCY` edges, apart from cycles that a reset has cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample present this cycle |
| in_sof | input | 1 | Sample opens a new frame |
| in_data | input | 32 | Signed input sample |
| out_valid | output | 1 | Filtered result present this cycle |
| out_sof | output | 1 | Result belongs to a frame-opening sample |
| out_data | output | 32 | Signed filtered result, wrapped modulo 2^32 |

## Verification
A corrupted history word shows up as a wrong `out_data` five edges after the next accepted sample, and it keeps showing for up to nine more samples before it shifts out. A frame controller that counts wrongly shows up as a misplaced `out_sof`, and also as a jump in `out_data` where history was cleared too early or too late. A broken valid or sum stage shows up within the five-edge latency as an output in the wrong cycle. For this reason the bench compares every cycle against an expected-output slot keyed to the cycle number.

// File: rtl/fir10_pkg.sv
package fir10_pkg;

    localparam int TAPS    = 10;
    localparam int DATA_W  = 32;

    // weight applied to the sample that is i positions old
    localparam int WEIGHT [TAPS] = '{13, -2, 9, 11, 26, 18, 95, -43, 6, 74};

    typedef enum logic {
        ST_IDLE,
        ST_RUN
    } frame_st_e;

endpackage

// File: rtl/fir10_frame_ctl.sv
module fir10_frame_ctl
    import fir10_pkg::*;
#(
    parameter int FRAME_LEN = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_sof,
    output logic new_frame
);
    localparam int IW = (FRAME_LEN > 2) ? $clog2(FRAME_LEN) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_LEN - 1);

    frame_st_e      st_q, st_d;
    logic [IW-1:0]  idx_q, idx_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            idx_q <= '0;
        end else begin
            st_q  <= st_d;
            idx_q <= idx_d;
        end
    end

    always_comb begin
        st_d      = st_q;
        idx_d     = idx_q;
        new_frame = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (in_valid) begin
                    new_frame = 1'b1;
                    idx_d     = '0;
                    st_d      = ST_RUN;
                end
            end
            ST_RUN: begin
                if (in_valid) begin
                    if (in_sof || idx_q == LAST_IDX) begin
                        new_frame = 1'b1;
                        idx_d     = '0;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // R8: the sample after the last of a frame restarts the index
    p_frame_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && st_q == ST_RUN && idx_q == LAST_IDX) |=> (idx_q == '0))
        else $error("frame index did not restart");

    // R7: a flagged sample always starts counting afresh
    p_sof_restart_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sof) |=> (idx_q == '0 && st_q == ST_RUN))
        else $error("flagged sample did not restart frame");

endmodule

// File: rtl/fir10_tap_line.sv
module fir10_tap_line #(
    parameter int W    = 32,
    parameter int TAPS = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                shift_en,
    input  logic                clr,
    input  logic signed [W-1:0] din,
    output logic signed [W-1:0] taps_q [TAPS]
);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < TAPS; i++) taps_q[i] <= '0;
        end else if (shift_en) begin
            for (int i = TAPS - 1; i > 0; i--) taps_q[i] <= clr ? '0 : taps_q[i-1];
            taps_q[0] <= din;
        end
    end

    // R4: no valid sample, no movement in the history
    p_hold_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> ($stable(taps_q[0]) && $stable(taps_q[TAPS-1])))
        else $error("history moved without a sample");

    // R5: each accepted sample moves the history one place
    p_shift_r5: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !clr) |=> (taps_q[1] == $past(taps_q[0]) &&
                                taps_q[TAPS-1] == $past(taps_q[TAPS-2])))
        else $error("history did not shift");

    p_newest_r5: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (taps_q[0] == $past(din)))
        else $error("newest sample not captured");

    // R7: frame start empties the older entries
    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (shift_en && clr) |=> (taps_q[1] == '0 && taps_q[TAPS-1] == '0))
        else $error("history not cleared at frame start");

endmodule

// File: rtl/fir10_mac_tree.sv
module fir10_mac_tree
    import fir10_pkg::*;
#(
    parameter int W      = 32,
    parameter int NTAP   = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_vld,
    input  logic                in_sof,
    input  logic signed [W-1:0] taps [NTAP],
    output logic                out_vld,
    output logic                out_sof,
    output logic signed [W-1:0] out_sum
);
    localparam int LVL    = $clog2(NTAP);
    localparam int TREE_N = 1 << LVL;

    function automatic logic signed [W-1:0] mul_lo(input logic signed [W-1:0] a,
                                                   input int c);
        logic signed [W-1:0] cw;
        cw = W'(c);
        return a * cw;
    endfunction

    for (genvar l = 0; l <= LVL; l++) begin : g_lvl
        localparam int CNT = TREE_N >> l;
        logic signed [W-1:0] sum_q [CNT];
        logic                vld_q;
        logic                sof_q;

        if (l == 0) begin : g_mul
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < CNT; i++) sum_q[i] <= '0;
                    vld_q <= 1'b0;
                    sof_q <= 1'b0;
                end else begin
                    for (int i = 0; i < NTAP; i++) sum_q[i] <= mul_lo(taps[i], WEIGHT[i]);
                    for (int i = NTAP; i < CNT; i++) sum_q[i] <= '0;
                    vld_q <= in_vld;
                    sof_q <= in_sof;
                end
            end
        end else begin : g_add
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int j = 0; j < CNT; j++) sum_q[j] <= '0;
                    vld_q <= 1'b0;
                    sof_q <= 1'b0;
                end else begin
                    for (int j = 0; j < CNT; j++)
                        sum_q[j] <= g_lvl[l-1].sum_q[2*j] + g_lvl[l-1].sum_q[2*j+1];
                    vld_q <= g_lvl[l-1].vld_q;
                    sof_q <= g_lvl[l-1].sof_q;
                end
            end

            // R10: valid advances one level per edge, never lost or invented
            p_vld_chain_r10: assert property (@(posedge clk) disable iff (rst)
                g_lvl[l-1].vld_q |=> vld_q)
                else $error("valid lost in adder tree");
            p_vld_none_r10: assert property (@(posedge clk) disable iff (rst)
                !g_lvl[l-1].vld_q |=> !vld_q)
                else $error("valid invented in adder tree");
        end
    end

    assign out_vld = g_lvl[LVL].vld_q;
    assign out_sof = g_lvl[LVL].sof_q;
    assign out_sum = g_lvl[LVL].sum_q[0];

endmodule

// File: rtl/fir_pipe10.sv
module fir_pipe10
    import fir10_pkg::*;
#(
    parameter int DW        = DATA_W,
    parameter int FRAME_LEN = 128
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic                 in_sof,
    input  logic signed [DW-1:0] in_data,
    output logic                 out_valid,
    output logic                 out_sof,
    output logic signed [DW-1:0] out_data
);
    // edges from the accepting edge to the result on the ports
    localparam int LATENCY = $clog2(TAPS) + 1;

    logic                 new_frame;
    logic signed [DW-1:0] hist [TAPS];
    logic                 hist_vld_q;
    logic                 hist_sof_q;

    fir10_frame_ctl #(.FRAME_LEN(FRAME_LEN)) u_frame (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .new_frame (new_frame)
    );

    fir10_tap_line #(.W(DW), .TAPS(TAPS)) u_taps (
        .clk      (clk),
        .rst      (rst),
        .shift_en (in_valid),
        .clr      (new_frame),
        .din      (in_data),
        .taps_q   (hist)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_vld_q <= 1'b0;
            hist_sof_q <= 1'b0;
        end else begin
            hist_vld_q <= in_valid;
            hist_sof_q <= new_frame;
        end
    end

    fir10_mac_tree #(.W(DW), .NTAP(TAPS)) u_tree (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (hist_vld_q),
        .in_sof  (hist_sof_q),
        .taps    (hist),
        .out_vld (out_valid),
        .out_sof (out_sof),
        .out_sum (out_data)
    );

    // R9: a frame marker only ever rides on a valid result
    p_sof_valid_r9: assert property (@(posedge clk) disable iff (rst)
        out_sof |-> out_valid)
        else $error("frame marker without valid output");

    // R10: tap stage carries valid one edge
    p_tap_vld_r10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> hist_vld_q)
        else $error("accepted sample lost at tap stage");

    initial begin
        assert (LATENCY == 5) else $error("unexpected pipeline depth");
    end

endmodule

// File: tb/test_fir_pipe10.sv
module test_fir_pipe10;

    localparam int LAT   = 5;
    localparam int FLEN  = 128;
    localparam int NSLOT = 64;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic               in_sof = 1'b0;
    logic signed [31:0] in_data = '0;
    logic               out_valid;
    logic               out_sof;
    logic signed [31:0] out_data;

    fir_pipe10 i_fir_pipe10 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
        .in_data(in_data), .out_valid(out_valid), .out_sof(out_sof),
        .out_data(out_data)
    );

    always #2.5 clk = ~clk;

    int  checks = 0;
    int  fails  = 0;
    int  cyc    = 0;
    bit  done   = 0;
    string req  = "R1";

    int  wt [10] = '{13, -2, 9, 11, 26, 18, 95, -43, 6, 74};
    int  m_hist [10];
    bit  m_idle = 1;
    int  m_idx  = 0;
    bit  exp_v [NSLOT];
    bit  exp_s [NSLOT];
    int  exp_d [NSLOT];
    logic [31:0] seed = 32'h1234_5678;

    always @(posedge clk) cyc <= cyc + 1;

    // cycle-keyed comparison of every output
    always @(negedge clk) begin
        if (!rst && !done) begin
            int s;
            s = cyc % NSLOT;
            checks++;
            if (out_valid !== exp_v[s]) begin
                fails++;
                $display("FAIL %s: cycle %0d out_valid=%0b expected %0b", req, cyc, out_valid, exp_v[s]);
            end else if (exp_v[s]) begin
                checks++;
                if (out_data !== exp_d[s] || out_sof !== exp_s[s]) begin
                    fails++;
                    $display("FAIL %s: cycle %0d out_data=%0d out_sof=%0b expected %0d sof %0b",
                             req, cyc, out_data, out_sof, exp_d[s], exp_s[s]);
                end
            end else begin
                checks++;
                if (out_sof !== 1'b0) begin
                    fails++;
                    $display("FAIL %s: cycle %0d out_sof=%0b expected 0", req, cyc, out_sof);
                end
            end
            exp_v[s] = 0;
        end
    end

    function automatic logic [31:0] rnd(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    // drive one cycle at a falling edge and record the expected result
    task automatic drive(input bit v, input bit s, input logic [31:0] d);
        in_valid = v;
        in_sof   = s;
        in_data  = d;
        if (v) begin
            bit nf;
            int acc;
            int sl;
            nf = m_idle || s || (m_idx == FLEN - 1);
            if (nf) begin
                for (int i = 0; i < 10; i++) m_hist[i] = 0;
                m_idx = 0;
            end else begin
                m_idx++;
            end
            m_idle = 0;
            for (int i = 9; i > 0; i--) m_hist[i] = m_hist[i-1];
            m_hist[0] = d;
            acc = 0;
            for (int i = 0; i < 10; i++) acc += wt[i] * m_hist[i];
            sl = (cyc + 1 + LAT) % NSLOT;
            exp_v[sl] = 1;
            exp_d[sl] = acc;
            exp_s[sl] = nf;
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) drive(0, 0, '0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        in_sof = 1'b0;
        for (int i = 0; i < NSLOT; i++) exp_v[i] = 0;
        for (int i = 0; i < 10; i++) m_hist[i] = 0;
        m_idle = 1;
        m_idx = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // R1: quiet outputs after reset, first sample sees empty history
    task automatic t_reset();
        req = "R1";
        idle(4);
        drive(1, 0, 32'd7);
        idle(LAT + 2);
    endtask

    // R2 R9: impulse response from a flagged frame start
    task automatic t_impulse();
        req = "R2";
        drive(1, 1, 32'd1);
        for (int k = 0; k < 11; k++) drive(1, 0, 32'd0);
        idle(LAT + 2);
    endtask

    // R3 R5 R6: back-to-back wide values, wrap-around arithmetic
    task automatic t_stream();
        req = "R3";
        drive(1, 0, 32'h7fff_ffff);
        drive(1, 0, 32'h8000_0000);
        drive(1, 0, 32'hffff_ffff);
        req = "R5";
        for (int k = 0; k < 40; k++) begin
            seed = rnd(seed);
            drive(1, 0, seed);
        end
        idle(LAT + 2);
    endtask

    // R4 R10: gaps must not shift history or create outputs
    task automatic t_gaps();
        req = "R4";
        for (int k = 0; k < 20; k++) begin
            seed = rnd(seed);
            drive(1, 0, seed);
            idle(k % 3);
        end
        idle(LAT + 2);
    endtask

    // R7 R9: flagged sample in mid-stream empties history
    task automatic t_sof_mid();
        req = "R7";
        for (int k = 0; k < 12; k++) drive(1, 0, 32'd1000 + 32'(k));
        drive(1, 1, 32'd3);
        for (int k = 0; k < 4; k++) drive(1, 0, 32'd5);
        idle(LAT + 2);
    endtask

    // R8 R9: automatic frame restart after FRAME_LEN samples
    task automatic t_frame_wrap();
        req = "R8";
        drive(1, 1, 32'd9);
        for (int k = 0; k < FLEN + 12; k++) drive(1, 0, 32'd9);
        idle(LAT + 2);
    endtask

    // R1: reset with results in flight discards them
    task automatic t_reset_mid();
        req = "R1";
        for (int k = 0; k < 4; k++) drive(1, 0, 32'd77);
        do_reset();
        idle(LAT + 3);
        drive(1, 0, 32'd2);
        drive(1, 0, 32'd0);
        idle(LAT + 2);
    endtask

    initial begin
        fork
            begin
                repeat (100000) @(posedge clk);
                fails++;
                $display("FAIL watchdog: run did not finish, expected completion");
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        join_none
        @(negedge clk);
        do_reset();
        t_reset();
        t_impulse();
        t_stream();
        t_gaps();
        t_sof_mid();
        t_frame_wrap();
        t_reset_mid();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule